// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the slave side of a small serial EEPROM that holds 1024 bytes in an on-chip register array. A host talks to it over a four-wire serial link: an active-low chip select, a serial clock that idles low, a serial data input and a serial data output. The link also has an active-low pause input. All link pins are brought into the system clock domain through two-stage synchronizers. Clock edges are then found by oversampling, so the serial clock must run well below the system clock.

Each transaction begins when chip select falls and ends when it rises. The first byte is an instruction. Array instructions then carry a two-byte address, followed by data in or data out. Writes go into a page buffer first. They reach the array only during a timed internal write cycle, which starts when chip select rises on a byte boundary. A write-enable latch gates every array write and status write, and it clears when the cycle finishes. The status register can be read at any time, including during the write cycle.

The serial output is a data/enable pair. Together the two pins form a tri-state driver: the line should float whenever the enable is low.

Top module: `ee_spi_slave`

## Requirements
- R1: After reset the status byte reads 0x00, every array byte reads 0xFF, and `so_en` is low.
- R2: The bus is clock mode 0, and all bytes travel MSB first. `mosi` is sampled on the rising edge of `sck`, and `so_data` changes after the falling edge. A transaction is one opcode byte, then, for array instructions, a 16-bit address of which only the low 10 bits are used. Opcodes: 0x06 set write enable, 0x04 clear write enable, 0x05 read status, 0x01 write status, 0x03 read array, 0x02 write array.
- R3: The status byte is {bit7 = status-write-disable flag, bits 6..2 = 0, bit1 = write-enable latch, bit0 = busy}. Opcode 0x06 sets bit 1, and opcode 0x04 clears it.
- R4: A write-array or write-status instruction issued while bit 1 is clear is ignored: no write cycle starts and no storage changes.
- R5: A read streams bytes for as long as chip select stays low. The address increments after each byte and wraps from 1023 to 0.
- R6: Write data fills a 32-byte page buffer. The offset within the page increments and wraps inside the page, and the upper address bits stay fixed.
- R7: A write cycle starts only if chip select rises when the bit count is a whole number of bytes and at least one data byte has arrived. Otherwise nothing is written and the write-enable latch keeps its value.
- R8: During a write cycle, status bit 0 reads 1 for WR_CYCLES system clocks. Read-status still works during that time, and every other instruction is ignored. When the cycle ends, bits 0 and 1 clear.
- R9: Write-status stores only bit 7 of its data byte into status bit 7, which resets to 0. The other status bits cannot be written.
- R10: While `hold_n` is low, `so_en` is low and `sck` and `mosi` are ignored. Once `hold_n` returns high, the transfer resumes at the same bit.
- R11: An unknown opcode is ignored, and so are all bytes after it, until chip select goes high.
- R12: `so_en` is high only during the data-out phase of a read-array or read-status instruction, with chip select low and `hold_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low transfer pause |
| so_data | output | 1 | Serial data to the host |
| so_en | output | 1 | Output enable for the serial data driver |

## Verification
The assertions assume the host keeps every `sck` level, `cs_n` change and `hold_n` change stable for several system clocks. This lets each change pass the synchronizers as one clean edge, in the same order it was driven. They also assume `hold_n` changes only while `sck` is low. The bench drives every pin from negative-edge-aligned tasks. Each `sck` half period lasts eight system clocks, and the bench leaves gaps around `cs_n` and the hold pause, so the stimulus stays within these limits.

// File: rtl/ee_spi_pkg.sv
package ee_spi_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_AHI,
    PH_ALO,
    PH_RD,
    PH_WR,
    PH_SRD,
    PH_SWR,
    PH_SKIP
  } phase_t;

endpackage

// File: rtl/ee_pin_sync.sv
module ee_pin_sync #(
  parameter int N = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] pin_s,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [2:0] stg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {3{RST_VAL[g]}};
      else        stg <= {stg[1:0], pin_i[g]};
    end
    assign pin_s[g]  = stg[1];
    assign rise_o[g] = stg[1] & ~stg[2];
    assign fall_o[g] = ~stg[1] & stg[2];
  end

endmodule

// File: rtl/ee_serial_fsm.sv
module ee_serial_fsm
  import ee_spi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic              hold_s,
  input  logic              busy,
  input  logic              wel,
  input  logic [7:0]        status,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              set_wel,
  output logic              clr_wel,
  output logic              pg_clr,
  output logic              pg_wr,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [7:0]        pg_data,
  output logic              commit_arr,
  output logic              commit_sr,
  output logic [7:0]        sr_data,
  output logic              so_data,
  output logic              so_en
);

  localparam int HI_W = ADDR_W - 8;

  phase_t            phase;
  logic [2:0]        bit_cnt;
  logic [6:0]        in_sr;
  logic [ADDR_W-1:0] addr;
  logic              got_byte;
  logic              is_wr;
  logic [7:0]        sr_byte;
  logic [7:0]        out_sr;
  logic              so_q;
  logic              cs_q;

  logic       step, shift_out, byte_done, cs_rise;
  logic [7:0] byte_now;
  logic       opc_ok;

  assign step      = sck_rise & ~cs_s & hold_s;
  assign shift_out = sck_fall & ~cs_s & hold_s;
  assign byte_now  = {in_sr, mosi_s};
  assign byte_done = step && (bit_cnt == 3'd7);
  assign cs_rise   = cs_s & ~cs_q;
  assign opc_ok    = byte_done && (phase == PH_OPC);

  assign set_wel    = opc_ok && !busy && (byte_now == OP_WREN);
  assign clr_wel    = opc_ok && !busy && (byte_now == OP_WRDI);
  assign pg_clr     = opc_ok && !busy && wel && (byte_now == OP_WRIT);
  assign pg_wr      = byte_done && (phase == PH_WR);
  assign pg_addr    = addr;
  assign pg_data    = byte_now;
  assign commit_arr = cs_rise && (phase == PH_WR)  && got_byte && (bit_cnt == 3'd0);
  assign commit_sr  = cs_rise && (phase == PH_SWR) && got_byte && (bit_cnt == 3'd0);
  assign sr_data    = sr_byte;
  assign rd_addr    = (phase == PH_ALO) ? {addr[ADDR_W-1:8], byte_now} : addr;

  assign so_data = so_q;
  assign so_en   = ~cs_s & hold_s & ((phase == PH_RD) || (phase == PH_SRD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OPC;
      bit_cnt  <= '0;
      in_sr    <= '0;
      addr     <= '0;
      got_byte <= 1'b0;
      is_wr    <= 1'b0;
      sr_byte  <= '0;
      out_sr   <= '0;
      so_q     <= 1'b0;
    end else if (cs_s) begin
      phase    <= PH_OPC;
      bit_cnt  <= '0;
      got_byte <= 1'b0;
    end else begin
      if (step) begin
        in_sr   <= byte_now[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done) begin
        unique case (phase)
          PH_OPC: begin
            if (busy && byte_now != OP_RDSR) begin
              phase <= PH_SKIP;
            end else begin
              unique case (byte_now)
                OP_RDSR: begin
                  out_sr <= status;
                  phase  <= PH_SRD;
                end
                OP_WRSR: phase <= wel ? PH_SWR : PH_SKIP;
                OP_READ: begin
                  is_wr <= 1'b0;
                  phase <= PH_AHI;
                end
                OP_WRIT: begin
                  is_wr <= 1'b1;
                  phase <= wel ? PH_AHI : PH_SKIP;
                end
                default: phase <= PH_SKIP;
              endcase
            end
          end
          PH_AHI: begin
            addr[ADDR_W-1:8] <= byte_now[HI_W-1:0];
            phase            <= PH_ALO;
          end
          PH_ALO: begin
            if (is_wr) begin
              addr  <= rd_addr;
              phase <= PH_WR;
            end else begin
              out_sr <= rd_data;
              addr   <= rd_addr + 1'b1;
              phase  <= PH_RD;
            end
          end
          PH_RD: begin
            out_sr <= rd_data;
            addr   <= addr + 1'b1;
          end
          PH_WR: begin
            addr     <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
            got_byte <= 1'b1;
          end
          PH_SRD: out_sr <= status;
          PH_SWR: begin
            sr_byte  <= byte_now;
            got_byte <= 1'b1;
          end
          default: ;
        endcase
      end
      if (shift_out && (phase == PH_RD || phase == PH_SRD)) begin
        so_q   <= out_sr[7];
        out_sr <= {out_sr[6:0], 1'b0};
      end
    end
  end

  AST_FRESH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s) |=> (phase == PH_OPC) && (bit_cnt == 3'd0)); // R2

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_s && !cs_s) |=> ($stable(bit_cnt) || cs_s)); // R10

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_arr && commit_sr)); // R7

endmodule

// File: rtl/ee_store.sv
module ee_store #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wel,
  input  logic              clr_wel,
  input  logic              pg_clr,
  input  logic              pg_wr,
  input  logic [ADDR_W-1:0] pg_addr,
  input  logic [7:0]        pg_data,
  input  logic              commit_arr,
  input  logic              commit_sr,
  input  logic [7:0]        sr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [7:0]        status,
  output logic              busy,
  output logic              wel
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES);

  logic [7:0]       mem   [DEPTH];
  logic [7:0]       buf_q [PAGE];
  logic [PAGE-1:0]  buf_v;
  logic [PG_W-1:0]  page_q;
  logic [CNT_W-1:0] cnt;
  logic             kind_sr;
  logic [7:0]       sr_hold;
  logic             srwd;
  logic             done;

  assign busy    = (cnt != '0);
  assign done    = (cnt == CNT_W'(1));
  assign status  = {srwd, 5'b0, wel, busy};
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      kind_sr <= 1'b0;
      sr_hold <= '0;
      srwd    <= 1'b0;
      wel     <= 1'b0;
      page_q  <= '0;
      buf_v   <= '0;
    end else begin
      if (set_wel) wel <= 1'b1;
      if (clr_wel) wel <= 1'b0;
      if (pg_clr)  buf_v <= '0;
      if (pg_wr) begin
        buf_v[pg_addr[PAGE_W-1:0]] <= 1'b1;
        page_q <= pg_addr[ADDR_W-1:PAGE_W];
      end
      if ((commit_arr || commit_sr) && !busy) begin
        cnt     <= CNT_LOAD;
        kind_sr <= commit_sr;
        sr_hold <= sr_data;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
      if (done) begin
        wel   <= 1'b0;
        buf_v <= '0;
        if (kind_sr) srwd <= sr_hold[7];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pg_wr) buf_q[pg_addr[PAGE_W-1:0]] <= pg_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else if (done && !kind_sr) begin
      for (int i = 0; i < PAGE; i++) begin
        if (buf_v[i]) mem[{page_q, PAGE_W'(i)}] <= buf_q[i];
      end
    end
  end

  AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_arr || commit_sr) |-> wel); // R4

  AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(commit_arr || commit_sr || set_wel || pg_wr)); // R8

  AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel); // R8

endmodule

// File: rtl/ee_spi_slave.sv
module ee_spi_slave #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic hold_n,
  output logic so_data,
  output logic so_en
);

  logic [3:0] pins_s, pins_r, pins_f;

  logic              set_wel, clr_wel, pg_clr, pg_wr, commit_arr, commit_sr;
  logic [ADDR_W-1:0] pg_addr, rd_addr;
  logic [7:0]        pg_data, sr_data, rd_data, status;
  logic              busy, wel;

  // bit order: {hold_n, mosi, sck, cs_n}; idle levels on reset
  ee_pin_sync #(.N(4), .RST_VAL(4'b1001)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({hold_n, mosi, sck, cs_n}),
    .pin_s  (pins_s),
    .rise_o (pins_r),
    .fall_o (pins_f)
  );

  ee_serial_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (pins_s[0]),
    .sck_rise   (pins_r[1]),
    .sck_fall   (pins_f[1]),
    .mosi_s     (pins_s[2]),
    .hold_s     (pins_s[3]),
    .busy       (busy),
    .wel        (wel),
    .status     (status),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .set_wel    (set_wel),
    .clr_wel    (clr_wel),
    .pg_clr     (pg_clr),
    .pg_wr      (pg_wr),
    .pg_addr    (pg_addr),
    .pg_data    (pg_data),
    .commit_arr (commit_arr),
    .commit_sr  (commit_sr),
    .sr_data    (sr_data),
    .so_data    (so_data),
    .so_en      (so_en)
  );

  ee_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_wel    (set_wel),
    .clr_wel    (clr_wel),
    .pg_clr     (pg_clr),
    .pg_wr      (pg_wr),
    .pg_addr    (pg_addr),
    .pg_data    (pg_data),
    .commit_arr (commit_arr),
    .commit_sr  (commit_sr),
    .sr_data    (sr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .status     (status),
    .busy       (busy),
    .wel        (wel)
  );

endmodule

// File: tb/ee_spi_slave_test.sv
module ee_spi_slave_test;

  localparam int HALF = 8;
  localparam int WRC  = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic so_data, so_en;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ee_spi_slave #(.WR_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .hold_n(hold_n), .so_data(so_data), .so_en(so_en)
  );

  // {16-bit address sent, data}; only the low 10 address bits select a byte
  localparam logic [23:0] VEC [8] = '{
    {16'h0000, 8'h3C}, {16'h03FF, 8'h5A}, {16'h0155, 8'hA5}, {16'h02AA, 8'h0F},
    {16'hFC12, 8'hC3}, {16'h0201, 8'h81}, {16'h0080, 8'h7E}, {16'h0333, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic o);
    mosi = b;
    tick(HALF);
    o = so_data;
    sck = 1'b1;
    tick(HALF);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_io(tx[i], rx[i]);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_hi();
    tick(HALF);
    cs_n = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); xfer(op, r); cs_hi();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] r;
    cs_lo(); xfer(8'h05, r); xfer(8'h00, s); cs_hi();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rd_status(s);
      if (!s[0]) break;
    end
  endtask

  task automatic write1(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] r;
    cmd1(8'h06);
    cs_lo(); xfer(8'h02, r); xfer(a[15:8], r); xfer(a[7:0], r); xfer(d, r); cs_hi();
    wait_idle();
  endtask

  task automatic read1(input logic [15:0] a, output logic [7:0] d);
    logic [7:0] r;
    cs_lo(); xfer(8'h03, r); xfer(a[15:8], r); xfer(a[7:0], r); xfer(8'h00, d); cs_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s, d, r;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    check("R1 so_en", {7'b0, so_en}, 8'h00);
    rd_status(s);
    check("R1 status", s, 8'h00);
    read1(16'h0010, d);
    check("R1 array", d, 8'hFF);

    // table walk: R2 framing, address masking
    foreach (VEC[i]) write1(VEC[i][23:8], VEC[i][7:0]);
    foreach (VEC[i]) begin
      read1({6'b0, VEC[i][17:8]}, d);
      check("R2 vector", d, VEC[i][7:0]);
    end

    // R3 write enable / disable
    cmd1(8'h06); rd_status(s); check("R3 set", s, 8'h02);
    cmd1(8'h04); rd_status(s); check("R3 clear", s, 8'h00);

    // R4 write without latch
    cs_lo(); xfer(8'h02, r); xfer(8'h01, r); xfer(8'h01, r); xfer(8'h22, r); cs_hi();
    rd_status(s); check("R4 no cycle", s, 8'h00);
    read1(16'h0101, d); check("R4 array kept", d, 8'hFF);

    // R5 sequential read wrapping 1023 -> 0
    cs_lo(); xfer(8'h03, r); xfer(8'h03, r); xfer(8'hFF, r);
    xfer(8'h00, d); check("R5 first", d, 8'h5A);
    xfer(8'h00, d); check("R5 wrap", d, 8'h3C);
    xfer(8'h00, d); check("R5 next", d, 8'hFF);
    cs_hi();

    // R6 page wrap: start at 0x03E, third byte lands at 0x020
    cmd1(8'h06);
    cs_lo(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h3E, r);
    xfer(8'hA0, r); xfer(8'hA1, r); xfer(8'hA2, r); cs_hi();
    // R8 busy visible and status readable during cycle
    rd_status(s); check("R8 busy", s, 8'h03);
    cs_lo(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h20, r);
    tick(HALF);
    check("R8 read ignored", {7'b0, so_en}, 8'h00);
    xfer(8'h00, d); cs_hi();
    wait_idle();
    rd_status(s); check("R8 end", s, 8'h00);
    read1(16'h003F, d); check("R6 in page", d, 8'hA1);
    read1(16'h0020, d); check("R6 wrapped", d, 8'hA2);
    read1(16'h0040, d); check("R6 next page", d, 8'hFF);

    // R7 chip select released mid byte
    cmd1(8'h06);
    cs_lo(); xfer(8'h02, r); xfer(8'h01, r); xfer(8'h00, r);
    for (int i = 0; i < 4; i++) bit_io(1'b1, r[0]);
    cs_hi();
    rd_status(s); check("R7 no cycle", s, 8'h02);
    read1(16'h0100, d); check("R7 array kept", d, 8'hFF);
    cmd1(8'h04);

    // R9 status write
    cmd1(8'h06);
    cs_lo(); xfer(8'h01, r); xfer(8'hFF, r); cs_hi();
    wait_idle();
    rd_status(s); check("R9 set", s, 8'h80);
    cmd1(8'h06);
    cs_lo(); xfer(8'h01, r); xfer(8'h00, r); cs_hi();
    wait_idle();
    rd_status(s); check("R9 clear", s, 8'h00);

    // R11 unknown opcode then a would-be enable byte
    cs_lo(); xfer(8'hAB, r); xfer(8'h06, r); cs_hi();
    rd_status(s); check("R11 ignored", s, 8'h00);

    // R10 hold mid byte, R12 enable during data out
    cs_lo(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h12, r);
    for (int i = 7; i >= 5; i--) bit_io(1'b0, d[i]);
    tick(HALF);
    check("R12 driving", {7'b0, so_en}, 8'h01);
    hold_n = 1'b0;
    tick(HALF);
    check("R10 released", {7'b0, so_en}, 8'h00);
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1; sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
    end
    hold_n = 1'b1;
    tick(HALF);
    for (int i = 4; i >= 0; i--) bit_io(1'b0, d[i]);
    cs_hi();
    check("R10 resumed", d, 8'hC3);
    check("R12 idle", {7'b0, so_en}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule